// File: doc/BRIEF.md
# Ethernet DMA Interrupt Status Register

This block gathers eight interrupt causes from a DMA-driven Ethernet controller into one status word. Each cause is raised by a one-cycle event pulse from the hardware. Software clears a cause by writing a 1 to its bit. A separate enable register gates the causes onto a single interrupt line.

Three of the causes are fatal: a memory error during DMA, a transmit abort and a receive FIFO overflow. While any of them is pending, a halt output tells the DMA engines to stop. The halt drops only after software has cleared every fatal cause.

The status read view also shows the current receive and transmit read pointers. These are live fields that come from outside the block, so one read returns both the pending causes and the ring positions. A single select line picks between the status word and the enable register for both reads and writes.

Top module: `eth_irq_status`

## Requirements
- R1: After reset the status bits, the enable mask, `irqOut` and `dmaHalt` are all zero.
- R2: A 1 on `evtPulse[i]` in a cycle sets status bit i at the next clock edge, and the bit stays set until it is cleared.
- R3: A write with `regSel`=0 clears every status bit whose `wrData` bit is 1 and leaves every bit whose `wrData` bit is 0 unchanged.
- R4: If an event pulse and a clearing write hit the same bit in the same cycle, the bit is set after the edge.
- R5: With `regSel`=0, `rdData` is laid out as follows: bits 7:0 are the status bits, bits 11:8 are the live `rxRdPtr`, and bits 24:16 are the live `txRdPtr`. Bits 15:12 and 31:25 read as zero.
- R6: A write with `regSel`=1 loads the enable mask from `wrData` and does not change the status bits. With `regSel`=1, `rdData` bits 7:0 read back the mask and all other bits read zero.
- R7: `irqOut` is 1 exactly when some status bit is 1 and its mask bit is 1.
- R8: `dmaHalt` is 1 while any of status bits 3, 4 or 7 is set. Bits 0, 1, 2, 5 and 6 never raise it. It falls in the cycle after the write that clears the last fatal bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Selects the register: 0 is status, 1 is enable mask |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data: clear bits for status, new value for mask |
| rdData | output | 32 | Read word for the selected register |
| evtPulse | input | 8 | One pulse line per interrupt cause |
| rxRdPtr | input | 4 | Current receive read pointer |
| txRdPtr | input | 9 | Current transmit read pointer |
| irqOut | output | 1 | Combined, enabled interrupt |
| dmaHalt | output | 1 | Stop request while a fatal cause is pending |

## Verification
The checker runs on every cycle and covers the following: an event pulse leaves its bit set at the next edge, even when a clearing write hits the same bit; the status word changes only by events or by clears on the status select; the interrupt never fires with an empty status; the halt falls only right after a status write; and the reserved read fields stay zero. Some behaviour needs the bench's scenarios instead. These are the exact bit packing of the live pointers, mask readback, the masking pattern behind `irqOut`, and the difference between fatal and non-fatal causes. The bench also checks that halt survives the clearing of one fatal bit while another is still pending.

// File: rtl/eth_irq_pkg.sv
package eth_irq_pkg;
  localparam int NUM_SRC = 8;

  // Causes that stop DMA: memory error, transmit abort, receive overflow
  localparam logic [NUM_SRC-1:0] FATAL_SET = 8'b1001_1000;

  typedef struct packed {
    logic               statusWr;   // clear pass on the status bits
    logic               maskWr;     // load of the enable mask
    logic [NUM_SRC-1:0] wrBits;     // bits carried with either strobe
  } irqStrobes_t;
endpackage

// File: rtl/eth_irq_ctrl.sv
module eth_irq_ctrl
  import eth_irq_pkg::*;
(
  input  logic               regSel,
  input  logic               wrEn,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [NUM_SRC-1:0] statusQ,
  input  logic [NUM_SRC-1:0] maskQ,
  output irqStrobes_t        strobes,
  output logic               irqOut,
  output logic               dmaHalt
);
  // Decode the register access into strobes for the datapath
  always_comb begin
    strobes.statusWr = wrEn && !regSel;
    strobes.maskWr   = wrEn && regSel;
    strobes.wrBits   = wrData;
  end

  // Interrupt and halt depend only on registered state
  always_comb begin
    irqOut  = |(statusQ & maskQ);
    dmaHalt = |(statusQ & FATAL_SET);
  end
endmodule

// File: rtl/eth_irq_datapath.sv
module eth_irq_datapath
  import eth_irq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int RX_PTR_W = 4,
  parameter int TX_PTR_W = 9,
  parameter int RX_LSB   = 8,
  parameter int TX_LSB   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  irqStrobes_t         strobes,
  input  logic                regSel,
  input  logic [NUM_SRC-1:0]  evtPulse,
  input  logic [RX_PTR_W-1:0] rxRdPtr,
  input  logic [TX_PTR_W-1:0] txRdPtr,
  output logic [NUM_SRC-1:0]  statusQ,
  output logic [NUM_SRC-1:0]  maskQ,
  output logic [DATA_W-1:0]   rdData
);
  // One flop per cause; a pulse wins over a clear in the same cycle
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic clrHit;
    assign clrHit = strobes.statusWr && strobes.wrBits[i];
    always_ff @(posedge clk) begin
      if (!rstN)            statusQ[i] <= 1'b0;
      else if (evtPulse[i]) statusQ[i] <= 1'b1;
      else if (clrHit)      statusQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               maskQ <= '0;
    else if (strobes.maskWr) maskQ <= strobes.wrBits;
  end

  // Read view: status word carries the live pointers
  always_comb begin
    rdData = '0;
    if (regSel) begin
      rdData[NUM_SRC-1:0] = maskQ;
    end else begin
      rdData[NUM_SRC-1:0]          = statusQ;
      rdData[RX_LSB +: RX_PTR_W]   = rxRdPtr;
      rdData[TX_LSB +: TX_PTR_W]   = txRdPtr;
    end
  end
endmodule

// File: rtl/eth_irq_status.sv
module eth_irq_status
  import eth_irq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int RX_PTR_W = 4,
  parameter int TX_PTR_W = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regSel,
  input  logic                wrEn,
  input  logic [NUM_SRC-1:0]  wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [NUM_SRC-1:0]  evtPulse,
  input  logic [RX_PTR_W-1:0] rxRdPtr,
  input  logic [TX_PTR_W-1:0] txRdPtr,
  output logic                irqOut,
  output logic                dmaHalt
);
  localparam int RX_LSB = 8;
  localparam int TX_LSB = 16;

  irqStrobes_t        strobes;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] maskQ;

  eth_irq_ctrl u_ctrl (
    .regSel  (regSel),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .statusQ (statusQ),
    .maskQ   (maskQ),
    .strobes (strobes),
    .irqOut  (irqOut),
    .dmaHalt (dmaHalt)
  );

  eth_irq_datapath #(
    .DATA_W   (DATA_W),
    .RX_PTR_W (RX_PTR_W),
    .TX_PTR_W (TX_PTR_W),
    .RX_LSB   (RX_LSB),
    .TX_LSB   (TX_LSB)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regSel   (regSel),
    .evtPulse (evtPulse),
    .rxRdPtr  (rxRdPtr),
    .txRdPtr  (txRdPtr),
    .statusQ  (statusQ),
    .maskQ    (maskQ),
    .rdData   (rdData)
  );
endmodule

// File: rtl/eth_irq_chk.sv
module eth_irq_chk #(
  parameter int DATA_W = 32,
  parameter int SRC_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regSel,
  input logic              wrEn,
  input logic [SRC_W-1:0]  wrData,
  input logic [SRC_W-1:0]  evtPulse,
  input logic [DATA_W-1:0] rdData,
  input logic              irqOut,
  input logic              dmaHalt,
  input logic [SRC_W-1:0]  statusQ
);
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |=> ((statusQ & $past(evtPulse)) == $past(evtPulse))); // R2

  AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !regSel && ((wrData & evtPulse) != '0))
      |=> ((statusQ & $past(wrData & evtPulse)) == $past(wrData & evtPulse))); // R4

  AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !regSel && evtPulse == '0)
      |=> (statusQ == ($past(statusQ) & ~$past(wrData)))); // R3

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((!wrEn || regSel) && evtPulse == '0) |=> $stable(statusQ)); // R6

  AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (statusQ != '0)); // R7

  AST_HALT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dmaHalt) |-> $past(wrEn && !regSel)); // R8

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[15:12] == '0) && (rdData[31:25] == '0)); // R5
endmodule

bind eth_irq_status eth_irq_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regSel   (regSel),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .evtPulse (evtPulse),
  .rdData   (rdData),
  .irqOut   (irqOut),
  .dmaHalt  (dmaHalt),
  .statusQ  (statusQ)
);

// File: tb/eth_irq_status_tb.sv
`timescale 1ns/1ps
module eth_irq_status_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regSel = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  evtPulse = '0;
  logic [3:0]  rxRdPtr = '0;
  logic [8:0]  txRdPtr = '0;
  logic [31:0] rdData;
  logic        irqOut;
  logic        dmaHalt;

  int testCount = 0;
  int failCount = 0;

  always #2.5 clk = ~clk;

  eth_irq_status dut_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .evtPulse(evtPulse), .rxRdPtr(rxRdPtr),
    .txRdPtr(txRdPtr), .irqOut(irqOut), .dmaHalt(dmaHalt)
  );

  typedef struct packed {
    logic       sel;
    logic       wr;
    logic [7:0] data;
    logic [7:0] evt;
    logic [7:0] expStatus;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'h00, 8'h01, 8'h01, 4'd2},  // R2 single event
    '{1'b0, 1'b0, 8'h00, 8'h06, 8'h07, 4'd2},  // R2 two events, earlier bit held
    '{1'b0, 1'b1, 8'h02, 8'h00, 8'h05, 4'd3},  // R3 clear one bit
    '{1'b0, 1'b1, 8'h00, 8'h00, 8'h05, 4'd3},  // R3 zero write keeps all
    '{1'b0, 1'b1, 8'h01, 8'h01, 8'h05, 4'd4},  // R4 pulse beats clear
    '{1'b1, 1'b1, 8'hFF, 8'h00, 8'h05, 4'd6},  // R6 mask write leaves status
    '{1'b0, 1'b0, 8'h00, 8'hF0, 8'hF5, 4'd2},  // R2 upper events
    '{1'b0, 1'b1, 8'hFF, 8'h00, 8'h00, 4'd3},  // R3 clear all
    '{1'b0, 1'b1, 8'h0A, 8'hAA, 8'hAA, 4'd4},  // R4 mixed overlap
    '{1'b0, 1'b1, 8'h55, 8'h00, 8'hAA, 4'd3}   // R3 clear of already-zero bits
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply one cycle of stimulus, then return to idle past the edge
  task automatic apply(input logic sel, input logic wr, input logic [7:0] data,
                       input logic [7:0] evt);
    @(negedge clk);
    regSel = sel; wrEn = wr; wrData = data; evtPulse = evt;
    @(negedge clk);
    regSel = 1'b0; wrEn = 1'b0; wrData = '0; evtPulse = '0;
    #1;
  endtask

  initial begin
    #1000000;
    failCount++;
    testCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 status", rdData, 32'h0);
    check("R1 irq/halt", {30'b0, irqOut, dmaHalt}, 32'h0);
    regSel = 1'b1; #1;
    check("R1 mask", rdData, 32'h0);
    regSel = 1'b0; #1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].sel, VECS[i].wr, VECS[i].data, VECS[i].evt);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), rdData,
            {24'h0, VECS[i].expStatus});
    end

    // R6 mask readback (mask written to FF in the table)
    regSel = 1'b1; #1;
    check("R6 mask readback", rdData, 32'h0000_00FF);
    regSel = 1'b0; #1;

    // R5 live pointer packing
    rxRdPtr = 4'hA; txRdPtr = 9'h1C3; #1;
    check("R5 layout", rdData, {7'b0, 9'h1C3, 4'b0, 4'hA, 8'hAA});
    regSel = 1'b1; #1;
    check("R5 mask view hides pointers", rdData, 32'h0000_00FF);
    regSel = 1'b0; rxRdPtr = 4'h3; txRdPtr = 9'h005; #1;
    check("R5 pointers live", rdData, {7'b0, 9'h005, 4'b0, 4'h3, 8'hAA});

    // Clear everything, then test the masking
    apply(1'b0, 1'b1, 8'hFF, 8'h00);
    apply(1'b1, 1'b1, 8'h10, 8'h00);
    apply(1'b0, 1'b0, 8'h00, 8'h02);
    check("R7 unmasked source no irq", {31'b0, irqOut}, 32'h0);
    apply(1'b0, 1'b0, 8'h00, 8'h20);
    check("R7 still masked", {31'b0, irqOut}, 32'h0);
    check("R8 nonfatal no halt", {31'b0, dmaHalt}, 32'h0);
    apply(1'b0, 1'b0, 8'h00, 8'h10);
    check("R7 enabled source irq", {31'b0, irqOut}, 32'h1);
    apply(1'b0, 1'b1, 8'h10, 8'h00);
    check("R7 irq drops on clear", {31'b0, irqOut}, 32'h0);

    // R8 halt across two fatal causes
    apply(1'b0, 1'b0, 8'h00, 8'h88);
    check("R8 fatal halt", {31'b0, dmaHalt}, 32'h1);
    apply(1'b0, 1'b1, 8'h08, 8'h00);
    check("R8 halt held by bit 7", {31'b0, dmaHalt}, 32'h1);
    @(negedge clk);
    regSel = 1'b0; wrEn = 1'b1; wrData = 8'h80;
    #1;
    check("R8 halt during clearing write", {31'b0, dmaHalt}, 32'h1);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    #1;
    check("R8 halt dropped after clear", {31'b0, dmaHalt}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule